// File: doc/BRIEF.md
# Six-Phase Video Sample Demultiplex Sequencer

This block accepts one 10-bit pixel code per dot and spreads the codes in turn across six held channel registers. Each register feeds one sample-and-hold channel of a panel driver. A line-start pulse rearms the sequencer: the first sample taken after that pulse falls is sample 1 of a new cycle. The channel order runs upward (1 to 6) or downward (6 to 1), depending on a direction select.

In single-chip mode every sample is kept, so six consecutive dots fill the six channels. In dual-chip mode two copies of the block share one pixel bus. A role select makes each copy keep only the odd-numbered or only the even-numbered samples, so each copy advances at half the dot rate and needs twelve dots to fill its six channels.

Once a set of six is complete, the channel outputs are loaded after a programmable phase trim. All six can load together, or channels 1 to 3 can load half a dot ahead of channels 4 to 6. The whole block runs on one clock at twice the dot rate. A dot enable marks every second edge of that clock, so the half-dot steps stay on a single clock edge.

Top module: `hexphase_demux`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first completed set, every channel output reads zero and every strobe is low.
- R2: A dot whose `line_start` is sampled low, following a dot sampled with `line_start` high, carries sample 1. Dots sampled while `line_start` is high are never stored in any channel.
- R3: In single-chip mode with `dir_up` high, sample n (counted from 1) is placed in channel ((n-1) mod 6)+1.
- R4: In single-chip mode with `dir_up` low, sample n is placed in channel 6-((n-1) mod 6).
- R5: In dual-chip mode with `role_odd` high, only odd samples are kept. Sample 2j-1 goes to channel j when `dir_up` is high, and to channel 7-j when it is low.
- R6: In dual-chip mode with `role_odd` low, only even samples are kept. Sample 2j goes to channel j when `dir_up` is high, and to channel 7-j when it is low.
- R7: With `split_grp` low, all six channels load their new values on the same `clk2x` edge.
- R8: With `split_grp` high, channels 4 to 6 load exactly one `clk2x` edge (half a dot) after channels 1 to 3.
- R9: Channels 1 to 3 load on the `clk2x` edge that is 3+D edges after the edge that sampled the last sample of the set. D equals `phase_trim` in single-chip mode and 2×`phase_trim` in dual-chip mode.
- R10: Each channel strobe is high for exactly one `clk2x` cycle, in the cycle its new value first appears. A channel value never changes while its strobe is low.
- R11: In single-chip mode, every six kept samples give one update of all channels. In dual-chip mode, every twelve dots give one update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the dot rate |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_en | input | 1 | High on every second `clk2x` edge; marks the edges that sample a dot |
| line_start | input | 1 | Line-start pulse, sampled on dot edges; its falling edge rearms the sequence |
| pix_in | input | 10 | Pixel code, sampled on dot edges |
| dir_up | input | 1 | 1: ascending channel order; 0: descending |
| dual_mode | input | 1 | 1: dual-chip mode; 0: single-chip mode |
| role_odd | input | 1 | Dual-chip mode only: 1 keeps odd samples, 0 keeps even samples |
| split_grp | input | 1 | 1: channels 4 to 6 load half a dot after channels 1 to 3 |
| phase_trim | input | 4 | Output phase delay, in half-dot steps (single) or whole-dot steps (dual) |
| ch_data | output | 60 | Channel values; channel c (1 to 6) occupies bits [10c-1 : 10c-10] |
| ch_stb | output | 6 | Per-channel update strobe; bit c-1 belongs to channel c |

## Verification
On every cycle the assertions check how the strobes relate to each other and to the held values. Channel values must stay still while their strobe is low. Strobes must be single-cycle. Channels 1 to 3 must fire together. Channels 4 to 6 must fire either in that same cycle or one cycle later, matching the group-select value in force at that edge. The bench's directed scenarios are the only place where the sample-to-channel mapping is shown, for every mode, role and direction. They also show that samples taken during the line-start pulse are discarded, that the exact load edge follows the phase trim, and that the number of updates per line is correct.

// File: rtl/hpd_pkg.sv
// Package: shared defaults and helper functions for the six-phase demultiplex sequencer.
// Assumes: the trim field is small enough that its largest delay fits an on-chip tap line.
package hpd_pkg;

    localparam int unsigned HPD_DW     = 10;
    localparam int unsigned HPD_NCH    = 6;
    localparam int unsigned HPD_TRIM_W = 4;

    // Largest delay in clk2x edges: a full trim in dual mode (two edges per step).
    function automatic int unsigned hpd_max_delay(input int unsigned trim_w);
        return 2 * ((1 << trim_w) - 1);
    endfunction

    // Number of sample slots in one sequence (odd and even samples of a dual pair).
    function automatic int unsigned hpd_seq_len(input int unsigned nch);
        return 2 * nch;
    endfunction

endpackage

// File: rtl/hpd_tapdelay.sv
// Module: selectable tap delay line, clocked every clk2x edge.
// Output q is input d delayed by (sel+1) edges; sel is kept at or below MAXD by the caller.
// Assumes: sel changes only while the line carries no enabled dots.
module hpd_tapdelay #(
    parameter int unsigned W     = 12,
    parameter int unsigned MAXD  = 30,
    localparam int unsigned SW   = $clog2(MAXD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  q
);

    logic [W-1:0] pipe [MAXD+1];

    // Shift the whole line by one stage per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j <= int'(MAXD); j++) pipe[j] <= '0;
        end else begin
            pipe[0] <= d;
            for (int j = 1; j <= int'(MAXD); j++) pipe[j] <= pipe[j-1];
        end
    end

    // Pick the tap named by sel; stage 0 is the fallback.
    always_comb begin
        q = pipe[0];
        for (int j = 1; j <= int'(MAXD); j++) begin
            if (sel == SW'(j)) q = pipe[j];
        end
    end

endmodule

// File: rtl/hpd_sequencer.sv
// Module: numbers the samples after each falling line-start, drops the ones this chip does
// not own, and turns each kept sample into a write of one channel slot.
// Assumes: x_en arrives at most every second edge; mode inputs are static during a line.
module hpd_sequencer #(
    parameter int unsigned DW   = 10,
    parameter int unsigned NCH  = 6,
    localparam int unsigned CYC    = 2 * NCH,
    localparam int unsigned IDX_W  = $clog2(CYC),
    localparam int unsigned SLOT_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_en,
    input  logic              x_ls,
    input  logic [DW-1:0]     x_pix,
    input  logic              dual_mode,
    input  logic              role_odd,
    input  logic              dir_up,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_ch,
    output logic [DW-1:0]     wr_data,
    output logic              wr_last
);

    logic              ls_prev;
    logic              s_en;
    logic              s_vld;
    logic [IDX_W-1:0]  s_idx;
    logic [DW-1:0]     s_pix;
    logic              fall;
    logic              keep;
    logic [IDX_W-1:0]  wrap_idx;
    logic [SLOT_W-1:0] slot;

    assign fall = ls_prev & ~x_ls;

    // Register each dot with its sample number; hold the sequence while line-start is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_prev <= 1'b0;
            s_en    <= 1'b0;
            s_vld   <= 1'b0;
            s_idx   <= '0;
            s_pix   <= '0;
        end else begin
            s_en <= x_en;
            if (x_en) begin
                ls_prev <= x_ls;
                s_pix   <= x_pix;
                if (x_ls)      s_vld <= 1'b0;
                else if (fall) s_vld <= 1'b1;
                if (fall || s_idx == IDX_W'(CYC - 1)) s_idx <= '0;
                else                                  s_idx <= s_idx + 1'b1;
            end
        end
    end

    // Ownership: in dual mode the odd-role copy keeps even indices (samples 1,3,5,...).
    assign keep = !dual_mode || (s_idx[0] != role_odd);

    // Slot within the set of six; single mode folds the twelve indices onto six.
    always_comb begin
        wrap_idx = (s_idx >= IDX_W'(NCH)) ? (s_idx - IDX_W'(NCH)) : s_idx;
        if (dual_mode) slot = s_idx[IDX_W-1:1];
        else           slot = wrap_idx[SLOT_W-1:0];
    end

    // Map the slot onto a channel according to the scan direction.
    assign wr_ch   = dir_up ? slot : (SLOT_W'(NCH - 1) - slot);
    assign wr_en   = s_en & s_vld & keep;
    assign wr_data = s_pix;
    assign wr_last = (slot == SLOT_W'(NCH - 1));

endmodule

// File: rtl/hpd_holdbank.sv
// Module: collects a set of six channel values, then loads them into the output
// registers, either all at once or as a leading and a trailing group of three.
// Assumes: NCH is even; consecutive completions are at least two edges apart.
module hpd_holdbank #(
    parameter int unsigned DW   = 10,
    parameter int unsigned NCH  = 6,
    localparam int unsigned HALF   = NCH / 2,
    localparam int unsigned SLOT_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_ch,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_last,
    input  logic              split_grp,
    output logic [NCH*DW-1:0] ch_data,
    output logic [NCH-1:0]    ch_stb
);

    logic [DW-1:0] shadow [NCH];
    logic          set_done;
    logic          tail_pend;
    logic          load_head;
    logic          load_tail;

    // Accept each kept sample into its slot of the collection bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NCH); i++) shadow[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(NCH); i++) begin
                if (wr_ch == SLOT_W'(i)) shadow[i] <= wr_data;
            end
        end
    end

    // Mark a complete set, and the trailing group that still waits half a dot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_done  <= 1'b0;
            tail_pend <= 1'b0;
        end else begin
            set_done  <= wr_en & wr_last;
            tail_pend <= set_done & split_grp;
        end
    end

    assign load_head = set_done;
    assign load_tail = (set_done & ~split_grp) | tail_pend;

    // One output register and strobe per channel; the group is chosen by position.
    for (genvar g = 0; g < int'(NCH); g++) begin : g_chan
        logic ld;
        if (g < int'(HALF)) begin : g_head
            assign ld = load_head;
        end else begin : g_tail
            assign ld = load_tail;
        end

        // Load the channel from the bank and flag the update for one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_data[g*DW +: DW] <= '0;
                ch_stb[g]           <= 1'b0;
            end else begin
                ch_stb[g] <= ld;
                if (ld) ch_data[g*DW +: DW] <= shadow[g];
            end
        end
    end

endmodule

// File: rtl/hexphase_demux.sv
// Module: top of the six-phase demultiplex sequencer. The dot-sampled inputs pass
// through a tap delay set by the phase trim, then the sequencer, then the hold bank.
// Assumes: clk2x runs at twice the dot rate and dot_en is high on every second edge;
// mode and trim inputs are changed only between lines.
module hexphase_demux #(
    parameter int unsigned DW     = hpd_pkg::HPD_DW,
    parameter int unsigned NCH    = hpd_pkg::HPD_NCH,
    parameter int unsigned TRIM_W = hpd_pkg::HPD_TRIM_W,
    localparam int unsigned MAXD   = hpd_pkg::hpd_max_delay(TRIM_W),
    localparam int unsigned SW     = $clog2(MAXD + 1),
    localparam int unsigned SLOT_W = $clog2(NCH),
    localparam int unsigned LW     = DW + 2
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              line_start,
    input  logic [DW-1:0]     pix_in,
    input  logic              dir_up,
    input  logic              dual_mode,
    input  logic              role_odd,
    input  logic              split_grp,
    input  logic [TRIM_W-1:0] phase_trim,
    output logic [NCH*DW-1:0] ch_data,
    output logic [NCH-1:0]    ch_stb
);

    logic [SW-1:0]     tap_sel;
    logic [LW-1:0]     line_in;
    logic [LW-1:0]     line_out;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_ch;
    logic [DW-1:0]     wr_data;
    logic              wr_last;

    // A trim step is one clk2x edge in single mode and two in dual mode.
    always_comb begin
        if (dual_mode) tap_sel = SW'({phase_trim, 1'b0});
        else           tap_sel = SW'(phase_trim);
    end

    assign line_in = {dot_en, line_start, pix_in};

    hpd_tapdelay #(
        .W    (LW),
        .MAXD (MAXD)
    ) u_dly (
        .clk   (clk2x),
        .rst_n (rst_n),
        .d     (line_in),
        .sel   (tap_sel),
        .q     (line_out)
    );

    hpd_sequencer #(
        .DW  (DW),
        .NCH (NCH)
    ) u_seq (
        .clk       (clk2x),
        .rst_n     (rst_n),
        .x_en      (line_out[LW-1]),
        .x_ls      (line_out[LW-2]),
        .x_pix     (line_out[DW-1:0]),
        .dual_mode (dual_mode),
        .role_odd  (role_odd),
        .dir_up    (dir_up),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .wr_last   (wr_last)
    );

    hpd_holdbank #(
        .DW  (DW),
        .NCH (NCH)
    ) u_bank (
        .clk       (clk2x),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .wr_last   (wr_last),
        .split_grp (split_grp),
        .ch_data   (ch_data),
        .ch_stb    (ch_stb)
    );

endmodule

// File: rtl/hpd_checker.sv
// Module: strobe and hold-timing properties of the demultiplex sequencer, bound to its top.
// Assumes: completed sets are never closer than two clk2x edges.
module hpd_checker #(
    parameter int unsigned DW  = 10,
    parameter int unsigned NCH = 6,
    localparam int unsigned HALF = NCH / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              split_grp,
    input logic [NCH*DW-1:0] ch_data,
    input logic [NCH-1:0]    ch_stb
);

    for (genvar g = 0; g < int'(NCH); g++) begin : g_prop
        // R10: a channel value moves only in its strobe cycle.
        a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_stb[g] |-> $stable(ch_data[g*DW +: DW]));
        // R10: a strobe lasts one cycle.
        a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            ch_stb[g] |=> !ch_stb[g]);
    end

    // R7: the leading three channels always fire together.
    a_r7_head_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ch_stb[HALF-1:0]) == 0) || ($countones(ch_stb[HALF-1:0]) == HALF));

    // R7: without splitting, the trailing group fires with the leading group.
    a_r7_joint_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_stb[0] && !$past(split_grp)) |-> ch_stb[NCH-1]);

    // R8: with splitting, the trailing group is not in the leading cycle...
    a_r8_tail_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_stb[0] && $past(split_grp)) |-> !ch_stb[NCH-1]);

    // R8: ...but in the very next one.
    a_r8_tail_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_stb[0] && $past(split_grp)) |=> ch_stb[NCH-1]);

endmodule

bind hexphase_demux hpd_checker #(
    .DW  (DW),
    .NCH (NCH)
) u_chk (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .split_grp (split_grp),
    .ch_data   (ch_data),
    .ch_stb    (ch_stb)
);

// File: tb/sim_hexphase_demux.sv
// Bench: directed scenarios, each a task that drives one line and checks its own results.
module sim_hexphase_demux;

    logic        clk2x = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0;
    logic        line_start = 1'b1;
    logic [9:0]  pix_in = '0;
    logic        dir_up = 1'b1;
    logic        dual_mode = 1'b0;
    logic        role_odd = 1'b1;
    logic        split_grp = 1'b0;
    logic [3:0]  phase_trim = '0;
    logic [59:0] ch_data;
    logic [5:0]  ch_stb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_stb [6];
    int cnt_stb [6];
    bit finished = 1'b0;

    always #4 clk2x = ~clk2x;   // 125 MHz

    hexphase_demux u0 (
        .clk2x(clk2x), .rst_n(rst_n), .dot_en(dot_en), .line_start(line_start),
        .pix_in(pix_in), .dir_up(dir_up), .dual_mode(dual_mode), .role_odd(role_odd),
        .split_grp(split_grp), .phase_trim(phase_trim), .ch_data(ch_data), .ch_stb(ch_stb)
    );

    always @(posedge clk2x) cyc <= cyc + 1;

    // Record the last strobe cycle and the strobe count of each channel.
    always @(negedge clk2x) begin
        for (int i = 0; i < 6; i++) begin
            if (ch_stb[i]) begin
                last_stb[i] = cyc;
                cnt_stb[i]  = cnt_stb[i] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One dot: inputs valid on a single clk2x edge; returns the count at that edge.
    task automatic dot(input logic ls, input logic [9:0] px, output int edge_c);
        @(negedge clk2x);
        dot_en = 1'b1; line_start = ls; pix_in = px;
        @(negedge clk2x);
        edge_c = cyc;
        dot_en = 1'b0;
    endtask

    // One line under a given mode; checks mapping (R2..R6), timing (R7..R9) and counts (R11).
    task automatic run_case(input bit dual, input bit role, input bit dir, input bit split,
                            input int trim, input int base);
        int c;
        int cs [13];
        int expv [6];
        int lastn;
        int k;
        string mreq;
        @(negedge clk2x);
        dual_mode = dual; role_odd = role; dir_up = dir; split_grp = split;
        phase_trim = 4'(trim);
        for (int i = 0; i < 6; i++) begin cnt_stb[i] = 0; last_stb[i] = -1; end
        repeat (34) @(negedge clk2x);
        for (int i = 0; i < 3; i++) dot(1'b1, 10'(10'h3F0 + i), c);
        for (int n = 1; n <= 12; n++) dot(1'b0, 10'(base + n), cs[n]);
        for (int i = 0; i < 4; i++) dot(1'b1, 10'h3E0, c);
        repeat (40) @(negedge clk2x);
        // Expected channel contents from the mapping rules.
        for (int n = 1; n <= 12; n++) begin
            int slot;
            bit kept;
            if (dual) begin
                kept = ((n % 2) == 1) == role;
                slot = (n - 1) / 2;
            end else begin
                kept = (n > 6);
                slot = (n - 1) % 6;
            end
            if (kept) expv[dir ? slot : 5 - slot] = base + n;
        end
        mreq  = dual ? (role ? "R5/R2" : "R6/R2") : (dir ? "R3/R2" : "R4/R2");
        lastn = (dual && role) ? 11 : 12;
        k     = dual ? 2 * trim : trim;
        for (int i = 0; i < 6; i++) begin
            int got;
            int et;
            got = int'(ch_data[i*10 +: 10]);
            check(got == expv[i], mreq, got, expv[i]);
            et = cs[lastn] + k + 3 + ((i >= 3 && split) ? 1 : 0);
            check(last_stb[i] == et, (i >= 3) ? (split ? "R8/R9" : "R7/R9") : "R9",
                  last_stb[i], et);
            check(cnt_stb[i] == (dual ? 1 : 2), "R11/R10", cnt_stb[i], dual ? 1 : 2);
        end
    endtask

    task automatic reset_check();
        repeat (4) @(negedge clk2x);
        check(ch_data == '0, "R1 data in reset", int'(ch_data[9:0]), 0);
        check(ch_stb == '0, "R1 strobe in reset", int'(ch_stb), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk2x);
        check(ch_data == '0, "R1 data after reset", int'(ch_data[9:0]), 0);
        check(ch_stb == '0, "R1 strobe after reset", int'(ch_stb), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        reset_check();
        run_case(1'b0, 1'b1, 1'b1, 1'b0,  0, 10'h010);
        run_case(1'b0, 1'b1, 1'b0, 1'b1,  3, 10'h040);
        run_case(1'b1, 1'b1, 1'b1, 1'b0,  2, 10'h080);
        run_case(1'b1, 1'b0, 1'b1, 1'b1,  0, 10'h0C0);
        run_case(1'b1, 1'b1, 1'b0, 1'b0,  5, 10'h100);
        run_case(1'b1, 1'b0, 1'b0, 1'b1, 15, 10'h140);
        run_case(1'b0, 1'b1, 1'b1, 1'b0, 15, 10'h180);
        run_case(1'b0, 1'b0, 1'b0, 1'b0,  1, 10'h1C0);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk2x);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule